// File: doc/BRIEF.md
# Fractional-Rate Audio Sample Decimator

This block sits behind a synthesizer core that delivers one signed sample on every chip cycle. It picks out the chip cycles on which an audio sample is taken for an output path running at a much lower rate. The ratio between the two rates is a fixed-point step of chip cycles per output sample, with 10 fractional bits, loaded through a configuration port. The default step is the rounded ratio of a 985248 Hz chip clock to a 44100 Hz output rate, which is 22877.

Chip cycles are marked by a `tick` enable. A fractional phase carries the leftover part of each interval forward, so the long-run output rate follows the step exactly. In nearest mode the sample is the core value on the chosen cycle, with a half-cycle rounding bias applied to the phase. In interpolation mode the output is a linear blend of the previous and current core values, weighted by the leftover fraction. Before use, every core value is shifted down and saturated to signed 16 bits. Each result appears with a one-cycle valid pulse.

Top module: `frac_decimator`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` is 0, the step is 22877 and nearest mode with a zero offset is active. With a tick on every cycle, the first sample is taken on tick 22.
- R2: A written step value below 1024 (one chip cycle) is raised to 1024.
- R3: Nearest mode (`mode_sel`=0) keeps an offset `o` in -512..511. Each interval computes `n = o + step + 512` and lasts `n>>10` ticks. The new offset is `(n & 1023) - 512`. The sample is the scaled core value of the last tick of the interval.
- R4: Interpolation mode (`mode_sel`=1) keeps an offset `o` in 0..1023. Each interval computes `n = o + step` and lasts `n>>10` ticks. The new offset is `n & 1023`.
- R5: In interpolation mode the sample is `p + ((w*(c-p)) >>> 10)`. Here `c` is the scaled core value of the last tick, `p` is the scaled value of the tick before it, and `w` is the new offset.
- R6: The value used as `p` is the scaled value of the preceding tick. A mode change resets it to 0.
- R7: The scaled value is `core_in >>> 4`, saturated to -32768..32767.
- R8: A step write is held pending and takes over at the next sample boundary. The phase is kept. A write in the same cycle as a sample tick applies at the boundary after that one.
- R9: When `mode_sel` differs from the mode in use, that cycle restarts the phase: offset 0, interval count 0, previous value 0. A tick in that cycle is discarded.
- R10: `out_valid` pulses high for one cycle, one clock after the sample tick. `out_data` changes only with that pulse and otherwise holds.
- R11: Cycles without `tick` neither advance the interval nor change the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | 0 nearest-cycle pick, 1 linear interpolation |
| cfg_we | input | 1 | Step write strobe |
| cfg_step | input | 32 | Chip cycles per sample, 22.10 fixed point |
| tick | input | 1 | One chip cycle has elapsed; `core_in` is valid |
| core_in | input | 24 | Signed core sample for this chip cycle |
| out_valid | output | 1 | One-cycle sample strobe |
| out_data | output | 16 | Signed saturated output sample |

## Verification
The bench goes after the cases where the phase arithmetic is easy to get off by one.

- **Rounding bias:** if the bias of 512 is dropped in nearest mode, or applied in interpolation mode, samples land one tick early or late.
- **Leftover fraction:** a design that stores the unwrapped phase drifts away from the reference model within a few samples.
- **Step timing:** a step applied immediately instead of at the boundary shortens the current interval.
- **Mode change:** a design that keeps the old previous value, or counts the tick in a mode-change cycle, emits a non-zero first interpolated sample or an early pulse.
- **Saturation:** extreme core values expose a missing clamp as wrapped output.
- **Minimum step:** an unfloored step below 1024 gives a zero-length interval and no pulse at all.

// File: rtl/decim_pkg.sv
package decim_pkg;
  typedef enum logic {
    PICK_NEAREST = 1'b0,
    PICK_LERP    = 1'b1
  } pick_mode_e;
endpackage

// File: rtl/sample_clamp.sv
module sample_clamp #(
  parameter int IN_W  = 24,
  parameter int SHIFT = 4,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  raw,
  output logic signed [OUT_W-1:0] clamped
);
  localparam logic signed [IN_W-1:0] HI = {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] LO = {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [IN_W-1:0] shifted;

  always_comb begin
    shifted = raw >>> SHIFT;
    if (shifted > HI)      clamped = HI[OUT_W-1:0];
    else if (shifted < LO) clamped = LO[OUT_W-1:0];
    else                   clamped = shifted[OUT_W-1:0];
  end
endmodule

// File: rtl/lerp_mix.sv
module lerp_mix #(
  parameter int W      = 16,
  parameter int FRAC_W = 10
) (
  input  logic signed [W-1:0]  prev_v,
  input  logic signed [W-1:0]  now_v,
  input  logic [FRAC_W-1:0]    weight,
  output logic signed [W-1:0]  mix
);
  localparam int PW = W + FRAC_W + 2;

  logic signed [W:0]    diff;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] sum;

  always_comb begin
    diff = {now_v[W-1], now_v} - {prev_v[W-1], prev_v};
    prod = PW'(diff) * PW'($signed({1'b0, weight}));
    sum  = (prod >>> FRAC_W) + PW'(prev_v);
    mix  = sum[W-1:0];
  end
endmodule

// File: rtl/rate_phase.sv
module rate_phase #(
  parameter int STEP_W = 32,
  parameter int FRAC_W = 10,
  parameter logic [STEP_W-1:0] DEF_STEP = 32'd22877,
  localparam int CNT_W = STEP_W - FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [FRAC_W-1:0] restart_phase,
  input  logic              tick,
  input  logic              cfg_we,
  input  logic [STEP_W-1:0] cfg_step,
  output logic              fire,
  output logic [FRAC_W-1:0] weight
);
  localparam logic [STEP_W-1:0] ONE  = STEP_W'(1) << FRAC_W;
  localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (FRAC_W - 1);

  logic [STEP_W-1:0] step_pend, step_act, step_floor;
  logic [FRAC_W-1:0] phase;
  logic [CNT_W-1:0]  elapsed;
  logic [STEP_W:0]   nxt;
  logic [CNT_W-1:0]  target;

  // phase holds offset+bias, always 0..1023 in both modes
  always_comb begin
    step_floor = (cfg_step < ONE) ? ONE : cfg_step;
    nxt        = {1'b0, step_act} + {{(STEP_W+1-FRAC_W){1'b0}}, phase};
    target     = nxt[STEP_W:FRAC_W];
    weight     = nxt[FRAC_W-1:0];
    fire       = tick && !restart && ((elapsed + CNT_W'(1)) == target);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_pend <= DEF_STEP;
      step_act  <= DEF_STEP;
      phase     <= HALF;
      elapsed   <= '0;
    end else begin
      if (cfg_we) step_pend <= step_floor;
      if (restart) begin
        phase   <= restart_phase;
        elapsed <= '0;
      end else if (tick) begin
        if (fire) begin
          phase    <= weight;
          elapsed  <= '0;
          step_act <= step_pend;
        end else begin
          elapsed <= elapsed + CNT_W'(1);
        end
      end
    end
  end

  p_step_floor_r2: assert property (@(posedge clk) disable iff (rst)
    step_act >= ONE);
  p_count_below_target_r3: assert property (@(posedge clk) disable iff (rst)
    elapsed < target);
  p_idle_keeps_phase_r11: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> ($stable(phase) && $stable(elapsed)));
  p_restart_zero_count_r9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (elapsed == '0));
endmodule

// File: rtl/frac_decimator.sv
module frac_decimator
  import decim_pkg::*;
#(
  parameter int IN_W    = 24,
  parameter int OUT_W   = 16,
  parameter int SHIFT   = 4,
  parameter int STEP_W  = 32,
  parameter int FRAC_W  = 10,
  parameter int CHIP_HZ = 985248,
  parameter int OUT_HZ  = 44100
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mode_sel,
  input  logic                    cfg_we,
  input  logic [STEP_W-1:0]       cfg_step,
  input  logic                    tick,
  input  logic signed [IN_W-1:0]  core_in,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  localparam longint DEF_L = (longint'(CHIP_HZ) * (longint'(1) << FRAC_W)
                              + longint'(OUT_HZ / 2)) / longint'(OUT_HZ);
  localparam logic [STEP_W-1:0] DEF_STEP = STEP_W'(DEF_L);
  localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (FRAC_W - 1);

  pick_mode_e               mode_q;
  logic                     restart;
  logic [FRAC_W-1:0]        restart_phase;
  logic                     fire;
  logic [FRAC_W-1:0]        weight;
  logic signed [OUT_W-1:0]  now_s, prev_s, mix;

  always_comb begin
    restart       = (pick_mode_e'(mode_sel) != mode_q);
    restart_phase = (pick_mode_e'(mode_sel) == PICK_NEAREST) ? HALF : '0;
  end

  rate_phase #(.STEP_W(STEP_W), .FRAC_W(FRAC_W), .DEF_STEP(DEF_STEP)) u_phase (
    .clk(clk), .rst(rst), .restart(restart), .restart_phase(restart_phase),
    .tick(tick), .cfg_we(cfg_we), .cfg_step(cfg_step),
    .fire(fire), .weight(weight)
  );

  sample_clamp #(.IN_W(IN_W), .SHIFT(SHIFT), .OUT_W(OUT_W)) u_clamp (
    .raw(core_in), .clamped(now_s)
  );

  lerp_mix #(.W(OUT_W), .FRAC_W(FRAC_W)) u_mix (
    .prev_v(prev_s), .now_v(now_s), .weight(weight), .mix(mix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= PICK_NEAREST;
      prev_s    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      mode_q    <= pick_mode_e'(mode_sel);
      out_valid <= fire;
      if (restart)   prev_s <= '0;
      else if (tick) prev_s <= now_s;
      if (fire) out_data <= (mode_q == PICK_LERP) ? mix : now_s;
    end
  end

  p_valid_after_tick_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(tick));
  p_data_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));
  p_prev_cleared_r6: assert property (@(posedge clk) disable iff (rst)
    restart |=> (prev_s == '0));
  p_mix_bounded_r5: assert property (@(posedge clk) disable iff (rst)
    (fire && mode_q == PICK_LERP) |->
      ((mix >= prev_s && mix <= now_s) || (mix <= prev_s && mix >= now_s)));
  p_sat_top_r7: assert property (@(posedge clk) disable iff (rst)
    ((core_in >>> SHIFT) > IN_W'((1 << (OUT_W-1)) - 1)) |-> (now_s == {1'b0, {(OUT_W-1){1'b1}}}));
endmodule

// File: tb/tb_frac_decimator.sv
module tb_frac_decimator;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_sel = 1'b0, cfg_we = 1'b0, tick = 1'b0;
  logic [31:0] cfg_step = '0;
  logic signed [23:0] core_in = '0;
  logic out_valid;
  logic signed [15:0] out_data;

  frac_decimator dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .cfg_we(cfg_we), .cfg_step(cfg_step),
    .tick(tick), .core_in(core_in), .out_valid(out_valid), .out_data(out_data)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  string tag = "R1";
  // reference model state
  int m_mode = 0, m_off = 0, m_prev = 0, m_el = 0, m_act = 22877, m_pend = 22877;
  bit exp_v = 1'b0;
  int exp_d = 0;
  int ticks_sent = 0, first_hit = 0, vcount = 0;

  // mode, step, tick gap, core slope, ticks
  localparam int VEC [6][5] = '{
    '{0, 3000, 1, 70001, 300},
    '{1, 3000, 1, 70001, 300},
    '{0, 1536, 2, -90000, 200},
    '{1, 2200, 3, 150007, 200},
    '{1, 22877, 1, 4099, 400},
    '{0, 1024, 1, 333, 50}
  };

  function automatic int scale(input int core);
    logic signed [23:0] c24;
    int s;
    c24 = 24'(core);
    s = int'(c24) >>> 4;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic check(input bit ok, input int act, input int expv, input string t);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", t, act, expv);
    end
  endtask

  task automatic compare();
    if (out_valid) vcount++;
    if (out_valid && first_hit == 0) first_hit = ticks_sent;
    if (exp_v || out_valid) begin
      check(out_valid === exp_v, int'(out_valid), int'(exp_v), {tag, " valid"});
      if (exp_v)
        check(int'(out_data) == exp_d, int'(out_data), exp_d, {tag, " data"});
    end
  endtask

  task automatic model(input bit t, input int core, input bit we, input int stp, input bit md);
    int ev, nxt, tgt, noff;
    exp_v = 1'b0;
    if (int'(md) != m_mode) begin
      m_mode = int'(md); m_off = 0; m_prev = 0; m_el = 0;
    end else if (t) begin
      ev = scale(core);
      m_el++;
      nxt = m_off + m_act + ((m_mode == 0) ? 512 : 0);
      tgt = nxt >>> 10;
      if (m_el == tgt) begin
        noff = (m_mode == 0) ? ((nxt & 1023) - 512) : (nxt & 1023);
        exp_d = (m_mode == 0) ? ev : m_prev + ((noff * (ev - m_prev)) >>> 10);
        exp_v = 1'b1;
        m_off = noff; m_el = 0; m_act = m_pend;
      end
      m_prev = ev;
    end
    if (we) m_pend = (stp < 1024) ? 1024 : stp;
  endtask

  task automatic cyc(input bit t, input int core, input bit we, input int stp, input bit md);
    @(negedge clk);
    compare();
    tick = t; core_in = 24'(core); cfg_we = we; cfg_step = 32'(stp); mode_sel = md;
    if (t && int'(md) == m_mode) ticks_sent++;
    model(t, core, we, stp, md);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid === 1'b0, int'(out_valid), 0, "R1 reset valid");
    check(out_data === 16'sd0, int'(out_data), 0, "R1 reset data");
    rst = 1'b0;
    // R1: default step, nearest, first sample on tick 22
    tag = "R1";
    for (int k = 1; k <= 30; k++) cyc(1'b1, k * 1000, 1'b0, 0, 1'b0);
    cyc(1'b0, 0, 1'b0, 0, 1'b0);
    check(first_hit == 22, first_hit, 22, "R1 first sample tick");

    // table walk: R3/R4 timing, R5 blend, R8 step change mid-run, R11 gaps
    for (int v = 0; v < 6; v++) begin
      int k;
      tag = (VEC[v][0] == 0) ? "R3/R8/R11" : "R4/R5/R8/R11";
      cyc(1'b0, 0, 1'b1, VEC[v][1], VEC[v][0] != 0);
      k = 0;
      while (k < VEC[v][4]) begin
        bool_step: begin end
        k++;
        cyc(1'b1, k * VEC[v][3], (k == VEC[v][4] / 2), VEC[v][1] + 517, VEC[v][0] != 0);
        for (int g = 1; g < VEC[v][2]; g++) cyc(1'b0, 0, 1'b0, 0, VEC[v][0] != 0);
      end
      cyc(1'b0, 0, 1'b0, 0, VEC[v][0] != 0);
    end

    // R2: step below one cycle is floored to 1024
    tag = "R2";
    cyc(1'b0, 0, 1'b1, 5, 1'b0);
    for (int k = 0; k < 40; k++) cyc(1'b1, 16 * k, 1'b0, 0, 1'b0);
    cyc(1'b0, 0, 1'b0, 0, 1'b0);
    vcount = 0;
    for (int k = 0; k < 10; k++) cyc(1'b1, 16 * k, 1'b0, 0, 1'b0);
    cyc(1'b0, 0, 1'b0, 0, 1'b0);
    check(vcount == 10, vcount, 10, "R2 sample per tick");

    // R7: saturation at both ends
    tag = "R7";
    cyc(1'b1, 32'h007FFFFF, 1'b0, 0, 1'b0);
    cyc(1'b0, 0, 1'b0, 0, 1'b0);
    check(int'(out_data) == 32767, int'(out_data), 32767, "R7 high clamp");
    cyc(1'b1, -8388608, 1'b0, 0, 1'b0);
    cyc(1'b0, 0, 1'b0, 0, 1'b0);
    check(int'(out_data) == -32768, int'(out_data), -32768, "R7 low clamp");

    // R9/R6: mode change drops tick and clears previous value
    tag = "R9";
    cyc(1'b1, 32'h00123456, 1'b0, 0, 1'b1);
    cyc(1'b0, 0, 1'b0, 0, 1'b1);
    check(out_valid === 1'b0, int'(out_valid), 0, "R9 tick dropped");
    tag = "R6";
    cyc(1'b1, 32'h00123456, 1'b0, 0, 1'b1);
    cyc(1'b0, 0, 1'b0, 0, 1'b1);
    check(out_valid === 1'b1 && int'(out_data) == 0, int'(out_data), 0, "R6 cleared prev");
    cyc(1'b1, 0, 1'b0, 0, 1'b1);
    cyc(1'b0, 0, 1'b0, 0, 1'b1);
    check(int'(out_data) == 32767, int'(out_data), 32767, "R6 prev is last tick");
    // R10: data holds without pulse
    tag = "R10";
    cyc(1'b0, 0, 1'b0, 0, 1'b1);
    check(out_valid === 1'b0 && int'(out_data) == 32767, int'(out_data), 32767, "R10 hold");
    cyc(1'b0, 0, 1'b0, 0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule